// File: doc/BRIEF.md
# Multi-mode up/down position counter channel

One channel of an up/down position counter for incremental encoders. The channel takes two encoder phase inputs and counts either from a quadrature signal pair at one, two or four counts per cycle, or from a count/direction pair. It counts in plain binary or in packed BCD digits. When the counter reaches a boundary it can wrap, stop at a limit, freeze and report an error, or wrap at a programmed modulus.

A host talks to the channel over a byte-wide write bus. A select line picks the control address or the data address. Data-address writes shift bytes into a preset register. Control-address writes either set the mode byte or issue a load or clear command. Both channels of a pair share one bus. Each channel is built with its own channel number, and a channel-select line picks which channel a write reaches. The low byte of the preset register also sets a programmable divider. The divider's output paces the sampling filter on the phase inputs, so slow mechanical edges and short glitches are rejected.

Top module: `qpc_channel`

## Requirements
- R1: Reset gives a count of 0, a clear overflow flag, up_o low and a mode byte of 0x00, which means binary, wrapping and count/direction operation.
- R2: A control-address write loads the mode byte only when data bits [6:5] are 01. It is accepted when data bit 7 is 1 (both channels) or when the channel select equals the channel number (bit 7 = 0). Any other control write leaves the mode byte unchanged.
- R3: The divider reloads from preset bits [7:0] (value N). It asserts fck_o for one cycle out of every N+1. With N = 0, fck_o stays high.
- R4: A phase input is taken into account only after it has been synchronised and has read the same value at two consecutive fck_o samples. A pulse shorter than one divider period causes no count.
- R5: Mode bits [4:3] = 00 is count/direction mode. A rising edge of quad_a makes one count, up when quad_b is 1 and down when quad_b is 0.
- R6: Mode bits [4:3] select the quadrature rate: 01 counts on the rising edge of A only, 10 counts on both edges of A, 11 counts on every single edge of A or B. Direction is up when A leads B (sequence AB = 00, 10, 11, 01). A change of both inputs at once is ignored.
- R7: With mode bit 0 = 0 the count is 24-bit binary. Under bound code 00 (bits [2:1]) it wraps from FFFFFF to 000000 and from 000000 to FFFFFF.
- R8: With mode bit 0 = 1 the count is six BCD digits. A digit carries after 9 (000009 goes to 000010), and the count wraps between 999999 and 000000.
- R9: Bound code 01 (range): a count up at the preset value, or a count down at 0, leaves the counter unchanged. Counting resumes with the first count in the other direction.
- R10: Bound code 10 (no-recycle): a count up at the top value or a count down at 0 sets the sticky flag ovf_o and leaves the counter unchanged. While the flag is set, no count changes the counter. Only reset, load or clear clears the flag.
- R11: Bound code 11 (modulo): a count up at the preset value gives 0, and a count down at 0 gives the preset value.
- R12: A data-address write with channel select equal to the channel number shifts the byte into the top of the preset register, so three writes are taken low byte first. A control write with bits [6:5] = 00 is a command: bit 1 clears the counter, bit 0 copies the preset into it, and clear wins over load. Both clear ovf_o. Channel matching works as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_data | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_ctl | input | 1 | 1 selects the control address, 0 the data address |
| bus_chsel | input | 1 | Channel select for the write |
| quad_a | input | 1 | Phase A, or the count input in count/direction mode |
| quad_b | input | 1 | Phase B, or the direction input in count/direction mode |
| count_o | output | CNT_W | Current count |
| mode_o | output | 8 | Current mode byte |
| ovf_o | output | 1 | Sticky no-recycle overflow/underflow flag |
| up_o | output | 1 | Direction of the most recent count event |
| fck_o | output | 1 | Filter sample enable from the divider |

## Verification
The bench builds the channel with CNT_W = 24, PSC_W = 8 and CH_ID = 1. A channel-select of 0 therefore reaches the channel only through the broadcast bit, so the rejection path in R2 and R12 is exercised. The full 24-bit width lets a load reach 999999 and the binary wrap at FFFFFF within a few edges. The 8-bit divider runs with preset low bytes of 0, 3, 5, 9 and 0x99, which covers the case where the filter sample period changes while an edge is still settling, as well as the fast and slow extremes of the N+1 division.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    // Boundary behaviour selected by mode bits [2:1]
    typedef enum logic [1:0] {
        BND_WRAP  = 2'b00,
        BND_RANGE = 2'b01,
        BND_HOLD  = 2'b10,
        BND_MOD   = 2'b11
    } bound_e;

    // Input decode selected by mode bits [4:3]
    typedef enum logic [1:0] {
        DEC_STEPDIR = 2'b00,
        DEC_X1      = 2'b01,
        DEC_X2      = 2'b10,
        DEC_X4      = 2'b11
    } decode_e;

    // Control-write key in bits [6:5]
    localparam logic [1:0] KEY_MODE = 2'b01;
    localparam logic [1:0] KEY_CMD  = 2'b00;

    localparam int PHASE_W = 2;  // {a, b}

endpackage

// File: rtl/qpc_prescaler.sv
module qpc_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] reload,
    output logic             tick
);

    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } psc_t;

    psc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == '0);
        if (tick) st_d.cnt = reload;
        else      st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/qpc_filter.sv
module qpc_filter #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] pin,
    output logic [W-1:0] level,
    output logic [W-1:0] level_prev
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
        logic [W-1:0] samp;
        logic [W-1:0] lvl;
        logic [W-1:0] prev;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.lvl;
        if (tick) begin
            st_d.samp = st_q.sync;
            for (int i = 0; i < W; i++) begin
                if (st_q.sync[i] == st_q.samp[i]) st_d.lvl[i] = st_q.sync[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level      = st_q.lvl;
    assign level_prev = st_q.prev;

endmodule

// File: rtl/qpc_decoder.sv
module qpc_decoder
    import qpc_pkg::*;
(
    input  decode_e              dec,
    input  logic [PHASE_W-1:0]   level,
    input  logic [PHASE_W-1:0]   level_prev,
    output logic                 step,
    output logic                 up
);

    logic a, b, pa, pb, ea, eb;

    always_comb begin
        a  = level[1];
        b  = level[0];
        pa = level_prev[1];
        pb = level_prev[0];
        ea = a ^ pa;
        eb = b ^ pb;
        // quadrature direction: A leading B counts up
        up = a ^ pb;
        unique case (dec)
            DEC_STEPDIR: begin
                step = a & ~pa;
                up   = b;
            end
            DEC_X1:  step = ea & ~eb & a;
            DEC_X2:  step = ea & ~eb;
            default: step = ea ^ eb;
        endcase
    end

endmodule

// File: rtl/qpc_core.sv
module qpc_core
    import qpc_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bcd,
    input  bound_e           bound,
    input  logic             step,
    input  logic             up,
    input  logic [CNT_W-1:0] preset,
    input  logic             load,
    input  logic             clear,
    output logic [CNT_W-1:0] count,
    output logic             flag,
    output logic             last_up
);

    localparam int               DIGITS  = CNT_W / 4;
    localparam logic [CNT_W-1:0] BCD_TOP = {DIGITS{4'h9}};
    localparam logic [CNT_W-1:0] BIN_TOP = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
        logic             up;
    } core_t;

    core_t st_d, st_q;

    function automatic logic [CNT_W-1:0] bcd_next(input logic [CNT_W-1:0] v, input logic inc);
        logic [CNT_W-1:0] r;
        logic             carry;
        logic [3:0]       dg;
        r     = v;
        carry = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            dg = v[4*i +: 4];
            if (carry) begin
                if (inc) begin
                    if (dg >= 4'd9) r[4*i +: 4] = 4'd0;
                    else begin r[4*i +: 4] = dg + 4'd1; carry = 1'b0; end
                end else begin
                    if (dg == 4'd0) r[4*i +: 4] = 4'd9;
                    else begin r[4*i +: 4] = dg - 4'd1; carry = 1'b0; end
                end
            end
        end
        return r;
    endfunction

    logic [CNT_W-1:0] nxt;
    logic             at_top, at_zero, at_preset;

    always_comb begin
        st_d      = st_q;
        nxt       = bcd ? bcd_next(st_q.cnt, up)
                        : (up ? st_q.cnt + 1'b1 : st_q.cnt - 1'b1);
        at_top    = bcd ? (st_q.cnt == BCD_TOP) : (st_q.cnt == BIN_TOP);
        at_zero   = (st_q.cnt == '0);
        at_preset = (st_q.cnt == preset);

        if (clear) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
        end else if (load) begin
            st_d.cnt  = preset;
            st_d.flag = 1'b0;
        end else if (step) begin
            st_d.up = up;
            unique case (bound)
                BND_WRAP: st_d.cnt = nxt;
                BND_RANGE: begin
                    if (!(up ? at_preset : at_zero)) st_d.cnt = nxt;
                end
                BND_HOLD: begin
                    if (!st_q.flag) begin
                        if (up ? at_top : at_zero) st_d.flag = 1'b1;
                        else                       st_d.cnt  = nxt;
                    end
                end
                default: begin
                    if (up) st_d.cnt = at_preset ? '0 : nxt;
                    else    st_d.cnt = at_zero ? preset : nxt;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign flag    = st_q.flag;
    assign last_up = st_q.up;

endmodule

// File: rtl/qpc_channel.sv
module qpc_channel
    import qpc_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int PSC_W = 8,
    parameter int CH_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_data,
    input  logic             bus_wr,
    input  logic             bus_ctl,
    input  logic             bus_chsel,
    input  logic             quad_a,
    input  logic             quad_b,
    output logic [CNT_W-1:0] count_o,
    output logic [7:0]       mode_o,
    output logic             ovf_o,
    output logic             up_o,
    output logic             fck_o
);

    localparam logic CH_BIT = 1'(CH_ID);

    typedef struct packed {
        logic [7:0]       mode;
        logic [CNT_W-1:0] preset;
    } regs_t;

    regs_t st_d, st_q;

    logic                ctl_wr, hit, mode_wr, cmd_wr, data_wr;
    logic                do_load, do_clear;
    logic [CNT_W-1:0]    preset_shift;
    logic [CNT_W-1:0]    preset_w;
    logic                tick, step, dir_up;
    logic [PHASE_W-1:0]  lvl, lvl_prev;

    if (CNT_W > 8) begin : g_wide
        assign preset_shift = {bus_data, st_q.preset[CNT_W-1:8]};
    end else begin : g_narrow
        assign preset_shift = bus_data;
    end

    always_comb begin
        ctl_wr   = bus_wr & bus_ctl;
        hit      = bus_data[7] | (bus_chsel == CH_BIT);
        mode_wr  = ctl_wr & hit & (bus_data[6:5] == KEY_MODE);
        cmd_wr   = ctl_wr & hit & (bus_data[6:5] == KEY_CMD);
        data_wr  = bus_wr & ~bus_ctl & (bus_chsel == CH_BIT);
        do_clear = cmd_wr & bus_data[1];
        do_load  = cmd_wr & bus_data[0];

        st_d = st_q;
        if (mode_wr) st_d.mode   = bus_data;
        if (data_wr) st_d.preset = preset_shift;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign preset_w = st_q.preset;

    qpc_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (st_q.preset[PSC_W-1:0]),
        .tick   (tick)
    );

    qpc_filter #(.W(PHASE_W)) u_flt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .pin        ({quad_a, quad_b}),
        .level      (lvl),
        .level_prev (lvl_prev)
    );

    qpc_decoder u_dec (
        .dec        (decode_e'(st_q.mode[4:3])),
        .level      (lvl),
        .level_prev (lvl_prev),
        .step       (step),
        .up         (dir_up)
    );

    qpc_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .bcd     (st_q.mode[0]),
        .bound   (bound_e'(st_q.mode[2:1])),
        .step    (step),
        .up      (dir_up),
        .preset  (st_q.preset),
        .load    (do_load),
        .clear   (do_clear),
        .count   (count_o),
        .flag    (ovf_o),
        .last_up (up_o)
    );

    assign mode_o = st_q.mode;
    assign fck_o  = tick;

endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
    parameter int CNT_W = 24,
    parameter int PSC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_ctl,
    input logic [1:0]       bus_key,
    input logic [CNT_W-1:0] count_o,
    input logic [7:0]       mode_o,
    input logic             ovf_o,
    input logic             fck_o,
    input logic [CNT_W-1:0] preset
);

    logic cmdw, dataw;
    assign cmdw  = bus_wr & bus_ctl & (bus_key == 2'b00);
    assign dataw = bus_wr & ~bus_ctl;

    // R7: binary wrapping mode moves by at most one per cycle
    p_binary_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o[2:0] == 3'b000 && !cmdw) |=>
        (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1 ||
         count_o == $past(count_o) - 1'b1));

    // R9: range mode never passes the upper limit
    p_range_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o[2:1] == 2'b01 && !cmdw && !dataw && count_o <= preset) |=>
        (count_o <= preset));

    // R10: sticky flag survives everything but a command
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !cmdw) |=> ovf_o);

    // R10: counter frozen while flagged in no-recycle mode
    p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && mode_o[2:1] == 2'b10 && !cmdw) |=> $stable(count_o));

    // R2: mode byte changes only through a keyed control write
    p_mode_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_wr && bus_ctl && bus_key == 2'b01)) |=> $stable(mode_o));

    // R3: with N at least 1 the sample enable is a single-cycle pulse
    p_fck_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fck_o && preset[PSC_W-1:0] != '0) |=> !fck_o);

endmodule

bind qpc_channel qpc_checker #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .bus_ctl (bus_ctl),
    .bus_key (bus_data[6:5]),
    .count_o (count_o),
    .mode_o  (mode_o),
    .ovf_o   (ovf_o),
    .fck_o   (fck_o),
    .preset  (preset_w)
);

// File: tb/tb_qpc_channel.sv
`timescale 1ns/1ps
module tb_qpc_channel;

    localparam int CNT_W  = 24;
    localparam int PSC_W  = 8;
    localparam int SETTLE = 2 * (1 << PSC_W) + 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bdata = 8'h00;
    logic        bwr = 1'b0, bctl = 1'b0, bsel = 1'b0;
    logic        qa = 1'b0, qb = 1'b0;
    logic [23:0] count_o;
    logic [7:0]  mode_o;
    logic        ovf_o, up_o, fck_o;

    int    checks = 0, failures = 0, cycles = 0;
    bit    armed = 0;
    string cur_req = "R1";
    int    qidx = 0;

    always #4 clk = ~clk;

    qpc_channel #(.CNT_W(CNT_W), .PSC_W(PSC_W), .CH_ID(1)) dut (
        .clk(clk), .rst_n(rst_n), .bus_data(bdata), .bus_wr(bwr), .bus_ctl(bctl),
        .bus_chsel(bsel), .quad_a(qa), .quad_b(qb), .count_o(count_o),
        .mode_o(mode_o), .ovf_o(ovf_o), .up_o(up_o), .fck_o(fck_o));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [1:0]  mpipe[$];
    logic [7:0]  mpc;
    logic [1:0]  msamp, mlvl, mprev;
    logic [23:0] mcnt, mpre;
    logic        mflag, mup;
    logic [7:0]  mmode;

    function automatic int bcd2int(input logic [23:0] v);
        int r = 0;
        for (int i = 5; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
        return r;
    endfunction

    function automatic logic [23:0] int2bcd(input int x);
        logic [23:0] r;
        for (int i = 0; i < 6; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    function automatic logic [23:0] mnext(input logic [23:0] c, input logic inc, input logic isbcd);
        if (isbcd) return int2bcd((bcd2int(c) + (inc ? 1 : 999999)) % 1000000);
        return inc ? c + 24'd1 : c - 24'd1;
    endfunction

    always @(posedge clk) begin : model
        logic       tk, ea, eb, stp, dir, hit, cw, clr, ld, isbcd;
        logic [1:0] m2c, nlvl;
        logic [23:0] nc, nx;
        logic       nf;
        if (!rst_n) begin
            mpipe = {2'b00, 2'b00};
            mpc = 0; msamp = 0; mlvl = 0; mprev = 0;
            mcnt = 0; mpre = 0; mflag = 0; mup = 0; mmode = 0;
        end else begin
            tk  = (mpc == 0);
            m2c = mpipe[0];
            void'(mpipe.pop_front());
            mpipe.push_back({qa, qb});
            nlvl = mlvl;
            if (tk) for (int i = 0; i < 2; i++) if (m2c[i] == msamp[i]) nlvl[i] = m2c[i];
            ea = mlvl[1] != mprev[1];
            eb = mlvl[0] != mprev[0];
            dir = mlvl[1] ^ mprev[0];
            case (mmode[4:3])
                2'b00: begin stp = mlvl[1] & ~mprev[1]; dir = mlvl[0]; end
                2'b01: stp = ea & ~eb & mlvl[1];
                2'b10: stp = ea & ~eb;
                default: stp = ea ^ eb;
            endcase
            cw  = bwr & bctl;
            hit = bdata[7] | bsel;
            clr = cw & hit & (bdata[6:5] == 2'b00) & bdata[1];
            ld  = cw & hit & (bdata[6:5] == 2'b00) & bdata[0];
            isbcd = mmode[0];
            nc = mcnt; nf = mflag;
            nx = mnext(mcnt, dir, isbcd);
            if (clr) begin nc = 0; nf = 0; end
            else if (ld) begin nc = mpre; nf = 0; end
            else if (stp) begin
                mup = dir;
                case (mmode[2:1])
                    2'b00: nc = nx;
                    2'b01: if (!(dir ? mcnt == mpre : mcnt == 0)) nc = nx;
                    2'b10: if (!mflag) begin
                        if (dir ? mcnt == (isbcd ? 24'h999999 : 24'hFFFFFF) : mcnt == 0) nf = 1;
                        else nc = nx;
                    end
                    default: nc = dir ? ((mcnt == mpre) ? 24'd0 : nx)
                                      : ((mcnt == 0) ? mpre : nx);
                endcase
            end
            if (cw && hit && bdata[6:5] == 2'b01) mmode = bdata;
            if (tk) begin mpc = mpre[7:0]; msamp = m2c; end
            else mpc = mpc - 8'd1;
            if (bwr && !bctl && bsel) mpre = {bdata, mpre[23:8]};
            mprev = mlvl; mlvl = nlvl; mcnt = nc; mflag = nf;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        cycles++;
        if (armed)
            chk(cur_req, {29'd0, ovf_o, up_o, fck_o, mode_o, count_o},
                         {29'd0, mflag, mup, (mpc == 0), mmode, mcnt});
    end

    // ---------------- stimulus helpers ----------------
    task automatic bus_write(input logic ctl, input logic sel, input logic [7:0] d);
        @(negedge clk); bwr = 1'b1; bctl = ctl; bsel = sel; bdata = d;
        @(negedge clk); bwr = 1'b0; bdata = 8'h00;
    endtask

    task automatic set_preset(input logic [23:0] v);
        bus_write(1'b0, 1'b1, v[7:0]);
        bus_write(1'b0, 1'b1, v[15:8]);
        bus_write(1'b0, 1'b1, v[23:16]);
    endtask

    task automatic pins(input logic a, input logic b);
        @(negedge clk); qa = a; qb = b;
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic qstep(input bit inc, input int n);
        for (int k = 0; k < n; k++) begin
            qidx = inc ? (qidx + 1) % 4 : (qidx + 3) % 4;
            pins(qidx == 1 || qidx == 2, qidx == 2 || qidx == 3);
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int per;
        @(posedge clk); @(negedge clk); armed = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 count", count_o, 0);
        chk("R1 mode", mode_o, 0);
        chk("R1 flags", {ovf_o, up_o}, 0);
        chk("R3 N=0 always high", fck_o, 1);

        cur_req = "R12";
        set_preset(24'h000005);
        bus_write(1'b0, 1'b0, 8'h77);          // other channel: ignored
        bus_write(1'b1, 1'b1, 8'h01);          // load
        @(negedge clk); chk("R12 load preset", count_o, 24'h5);
        bus_write(1'b1, 1'b1, 8'h02);          // clear
        @(negedge clk); chk("R12 clear", count_o, 0);

        cur_req = "R3";
        while (!fck_o) @(negedge clk);
        per = 0;
        do begin @(negedge clk); per++; end while (!fck_o);
        chk("R3 period N+1", per, 6);

        cur_req = "R2";
        bus_write(1'b1, 1'b1, 8'h48);  @(negedge clk);
        chk("R2 wrong key ignored", mode_o, 8'h00);
        bus_write(1'b1, 1'b0, 8'h28);  @(negedge clk);
        chk("R2 other channel ignored", mode_o, 8'h00);
        bus_write(1'b1, 1'b0, 8'hA8);  @(negedge clk);
        chk("R2 broadcast accepted", mode_o, 8'hA8);

        cur_req = "R5";
        bus_write(1'b1, 1'b1, 8'h20);
        pins(1'b0, 1'b1);
        for (int k = 0; k < 3; k++) begin pins(1'b1, 1'b1); pins(1'b0, 1'b1); end
        chk("R5 three up counts", count_o, 24'd3);
        pins(1'b0, 1'b0); pins(1'b1, 1'b0); pins(1'b0, 1'b0);
        chk("R5 one down count", count_o, 24'd2);

        cur_req = "R4";
        @(negedge clk); qa = 1'b1; @(negedge clk); qa = 1'b0;
        repeat (SETTLE) @(negedge clk);
        chk("R4 glitch rejected", count_o, 24'd2);
        qidx = 0;

        cur_req = "R6";
        bus_write(1'b1, 1'b1, 8'h28); qstep(1, 8);
        chk("R6 1X two cycles", count_o, 24'd4);
        bus_write(1'b1, 1'b1, 8'h30); qstep(1, 4);
        chk("R6 2X one cycle", count_o, 24'd6);
        bus_write(1'b1, 1'b1, 8'h38); qstep(1, 4);
        chk("R6 4X one cycle up", count_o, 24'd10);
        qstep(0, 4);
        chk("R6 4X one cycle down", count_o, 24'd6);
        chk("R6 direction down", up_o, 1'b0);

        cur_req = "R7";
        bus_write(1'b1, 1'b1, 8'h02);
        qstep(0, 1); chk("R7 underflow wrap", count_o, 24'hFFFFFF);
        qstep(1, 1); chk("R7 overflow wrap", count_o, 24'h000000);

        cur_req = "R8";
        bus_write(1'b1, 1'b1, 8'h39);
        set_preset(24'h999999);
        bus_write(1'b1, 1'b1, 8'h01);
        qstep(1, 1); chk("R8 999999 up wraps", count_o, 24'h000000);
        qstep(0, 1); chk("R8 000000 down wraps", count_o, 24'h999999);
        set_preset(24'h000009);
        bus_write(1'b1, 1'b1, 8'h01);
        qstep(1, 1); chk("R8 digit carry", count_o, 24'h000010);

        cur_req = "R9";
        set_preset(24'h000003);
        bus_write(1'b1, 1'b1, 8'h3A);
        bus_write(1'b1, 1'b1, 8'h02);
        qstep(1, 3); chk("R9 reach upper", count_o, 24'd3);
        qstep(1, 2); chk("R9 hold upper", count_o, 24'd3);
        qstep(0, 1); chk("R9 resume down", count_o, 24'd2);
        bus_write(1'b1, 1'b1, 8'h02);
        qstep(0, 2); chk("R9 hold at zero", count_o, 24'd0);
        qstep(1, 1); chk("R9 resume up", count_o, 24'd1);

        cur_req = "R10";
        bus_write(1'b1, 1'b1, 8'h3C);
        bus_write(1'b1, 1'b1, 8'h02);
        qstep(0, 1);
        chk("R10 underflow stops", count_o, 24'd0);
        chk("R10 flag set", ovf_o, 1'b1);
        qstep(1, 2);
        chk("R10 frozen while flagged", count_o, 24'd0);
        chk("R10 flag sticky", ovf_o, 1'b1);
        bus_write(1'b1, 1'b1, 8'h01); @(negedge clk);
        chk("R10 load clears flag", {ovf_o, count_o}, {1'b0, 24'd3});
        qstep(1, 1); chk("R10 counts after load", count_o, 24'd4);

        cur_req = "R11";
        bus_write(1'b1, 1'b1, 8'h3E);
        bus_write(1'b1, 1'b1, 8'h02);
        qstep(1, 3); chk("R11 reach modulus", count_o, 24'd3);
        qstep(1, 1); chk("R11 up wraps to 0", count_o, 24'd0);
        qstep(0, 1); chk("R11 down wraps to preset", count_o, 24'd3);
        qstep(0, 1); chk("R11 plain down", count_o, 24'd2);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule